// File: doc/BRIEF.md
# Dual-Tone DDS Channel Generator

One channel of a multi-channel sample source. On every clock it produces one signed sample for a DAC. The sample is either the saturated sum of two direct-digital-synthesis tones or an external streamed sample. Each tone has its own 16-bit tuning word, 16-bit phase offset and 16-bit sign-magnitude gain. The tones are built from a quarter-wave sine table that uses symmetry to cover the full circle.

Tone settings arrive on input ports but stay in a shadow position until a sync strobe. The strobe copies them into the active set and clears both phase accumulators. Channels that share one strobe therefore start together and stay aligned. A 4-bit source-select input chooses between the tone sum, the external stream and silence. The enable input gates both the output and the phase advance.

Top module: `dds_dual_tone_chan`

## Requirements
- R1: While rst_n is low, and on the first cycles after it is released, sample_out is 0. All active tone settings and both accumulators reset to 0, so no tone sounds before the first sync.
- R2: Each enabled cycle, a tone's accumulator advances by its tuning word modulo 2^16. The table phase is the accumulator plus the phase offset, modulo 2^16. Its top 12 bits k select the angle (k+0.5)·2π/4096, and the table value is round(32767·sin(angle)).
- R3: The gain is sign-magnitude. Bit 15 is the sign (1 = negative) and bits 14:0 are a magnitude with 14 fractional bits, so 0x4000 is a gain of 1.0 and 0x7FFF is just under 2.0.
- R4: The output is the sum of the two scaled tones, clamped to the range -32768 to 32767 instead of wrapping.
- R5: Consider the clock edge that samples sync high. The output for accumulator value n·word (n = 0, 1, …) appears after edge n+3 counted from that edge. When only the phase offset changes, edges 1 and 2 still show the previous settings.
- R6: Changes on the tuning, phase and gain inputs have no effect on the output until sync is sampled high.
- R7: A sync strobe loads the active settings of both tones and clears both accumulators to 0.
- R8: With enable low, sample_out is 0 after the next edge and the accumulators hold their value. When enable returns, the sequence resumes from the held value.
- R9: With data_sel = 2 and enable high, sample_out equals ext_sample delayed by one clock.
- R10: With data_sel = 0 the tone sum is output. Any other code except 2 outputs 0.
- R11: A tuning word of 0x8000 (half the sample rate) gives a sequence that alternates between the phases p and p+0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel run; low forces zero output and freezes the accumulators |
| sync | input | 1 | Strobe that applies the shadow settings and realigns phase |
| tone_freq | input | 2x16 | Tuning word per tone |
| tone_phase | input | 2x16 | Phase offset per tone (0xFFFF is almost a full turn) |
| tone_scale | input | 2x16 | Sign-magnitude gain per tone, 1.1.14 |
| data_sel | input | 4 | Source code: 0 tone sum, 2 external, others silent |
| ext_sample | input | 16 | External streamed sample, signed |
| sample_out | output | 16 | Signed output sample |

## Verification
The tone path has three registers between the accumulator and the pin: table read, gain multiply and output select. The bench therefore waits three falling edges after the edge that sampled sync before it compares sample n with n·word. It then compares one sample on every falling edge after that. The external path has one register, so each value driven on a falling edge is checked on the next one. After enable returns, the held accumulator shows for three samples before the sequence advances, and the bench predicts exactly that pattern. Expected tone values come from real-valued sine arithmetic with a tolerance of a few LSBs. Saturation, pass-through and silence are compared exactly.

// File: rtl/dds_chan_pkg.sv
package dds_chan_pkg;

   // Source-select codes decoded by the output stage
   localparam logic [3:0] SEL_TONE = 4'd0;
   localparam logic [3:0] SEL_EXT  = 4'd2;

   // pi scaled by 2^30
   localparam longint PI_Q30 = 64'sd3373259426;

   // Quarter-wave entry idx of a table of depth entries, centred in its bin,
   // scaled to amp. Integer Taylor series in Q30, so it folds at elaboration.
   function automatic longint quarter_sine(input int idx, input int depth, input longint amp);
      longint x;
      longint x2;
      longint term;
      longint total;
      x     = (longint'(2 * idx + 1) * PI_Q30) / longint'(4 * depth);
      x2    = (x * x) >>> 30;
      term  = x;
      total = x;
      for (int k = 1; k <= 7; k++) begin
         term  = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
         total = total + term;
      end
      return (total * amp + (64'sd1 <<< 29)) >>> 30;
   endfunction

endpackage

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
   parameter int DW     = 16,
   parameter int LUT_AW = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LUT_AW+1:0]          idx,
   output logic signed [DW-1:0]       sine_q
);
   import dds_chan_pkg::*;

   localparam int     QDEPTH = 1 << LUT_AW;
   localparam longint AMP    = (64'sd1 <<< (DW - 1)) - 1;

   if (LUT_AW < 2 || LUT_AW > 12) begin : g_bad_aw
      $error("dds_sine_lut: LUT_AW out of range");
   end
   if (DW < 8 || DW > 24) begin : g_bad_dw
      $error("dds_sine_lut: DW out of range");
   end

   logic [DW-2:0] rom [QDEPTH];

   for (genvar i = 0; i < QDEPTH; i++) begin : g_rom
      assign rom[i] = (DW-1)'(quarter_sine(i, QDEPTH, AMP));
   end

   logic [LUT_AW-1:0] offs;
   logic [LUT_AW-1:0] addr;
   logic              mirror;
   logic              negate;

   always_comb begin
      offs   = idx[LUT_AW-1:0];
      mirror = idx[LUT_AW];
      negate = idx[LUT_AW+1];
      addr   = mirror ? ~offs : offs;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sine_q <= '0;
      end else if (negate) begin
         sine_q <= -$signed({1'b0, rom[addr]});
      end else begin
         sine_q <= $signed({1'b0, rom[addr]});
      end
   end

endmodule

// File: rtl/dds_tone.sv
module dds_tone #(
   parameter int PW     = 16,
   parameter int DW     = 16,
   parameter int SW     = 16,
   parameter int LUT_AW = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 sync,
   input  logic [PW-1:0]        freq_i,
   input  logic [PW-1:0]        phase_i,
   input  logic [SW-1:0]        scale_i,
   output logic signed [DW:0]   tone_q
);
   localparam int IW   = LUT_AW + 2;
   localparam int TW   = DW + 1;
   localparam int FRAC = SW - 2;
   localparam int PWID = DW + SW;

   if (IW > PW) begin : g_bad_iw
      $error("dds_tone: table index wider than phase");
   end
   if (SW < 3) begin : g_bad_sw
      $error("dds_tone: scale too narrow");
   end

   logic [PW-1:0]         acc;
   logic [PW-1:0]         act_freq;
   logic [PW-1:0]         act_phase;
   logic [SW-1:0]         act_scale;
   logic [IW-1:0]         lut_idx;
   logic signed [DW-1:0]  sine_s1;
   logic signed [TW-1:0]  scaled_c;

   // Active settings load only on sync; the accumulator restarts there
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc       <= '0;
         act_freq  <= '0;
         act_phase <= '0;
         act_scale <= '0;
      end else if (sync) begin
         acc       <= '0;
         act_freq  <= freq_i;
         act_phase <= phase_i;
         act_scale <= scale_i;
      end else if (enable) begin
         acc <= acc + act_freq;
      end
   end

   assign lut_idx = IW'((acc + act_phase) >> (PW - IW));

   dds_sine_lut #(
      .DW     (DW),
      .LUT_AW (LUT_AW)
   ) u_lut (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx    (lut_idx),
      .sine_q (sine_s1)
   );

   assign scaled_c = TW'((PWID'(sine_s1) * PWID'($signed({1'b0, act_scale[SW-2:0]}))) >>> FRAC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tone_q <= '0;
      end else if (act_scale[SW-1]) begin
         tone_q <= -scaled_c;
      end else begin
         tone_q <= scaled_c;
      end
   end

   // R6
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync |=> ($stable(act_freq) && $stable(act_phase) && $stable(act_scale)));

   // R7
   sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> (acc == '0));

   // R8
   acc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !sync) |=> $stable(acc));

endmodule

// File: rtl/dds_dual_tone_chan.sv
module dds_dual_tone_chan #(
   parameter int PW        = 16,
   parameter int DW        = 16,
   parameter int SW        = 16,
   parameter int LUT_AW    = 10,
   parameter int NUM_TONES = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              enable,
   input  logic                              sync,
   input  logic [NUM_TONES-1:0][PW-1:0]      tone_freq,
   input  logic [NUM_TONES-1:0][PW-1:0]      tone_phase,
   input  logic [NUM_TONES-1:0][SW-1:0]      tone_scale,
   input  logic [3:0]                        data_sel,
   input  logic signed [DW-1:0]              ext_sample,
   output logic signed [DW-1:0]              sample_out
);
   import dds_chan_pkg::*;

   localparam int TW   = DW + 1;
   localparam int SUMW = TW + $clog2(NUM_TONES) + 1;
   localparam logic signed [SUMW-1:0] SAT_HI = SUMW'((64'sd1 <<< (DW - 1)) - 1);
   localparam logic signed [SUMW-1:0] SAT_LO = -SAT_HI - SUMW'(1);

   if (NUM_TONES < 1 || NUM_TONES > 8) begin : g_bad_nt
      $error("dds_dual_tone_chan: NUM_TONES out of range");
   end

   logic signed [TW-1:0]   tone_val [NUM_TONES];
   logic signed [SUMW-1:0] tone_sum;
   logic signed [DW-1:0]   sat_val;

   for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
      dds_tone #(
         .PW     (PW),
         .DW     (DW),
         .SW     (SW),
         .LUT_AW (LUT_AW)
      ) u_tone (
         .clk     (clk),
         .rst_n   (rst_n),
         .enable  (enable),
         .sync    (sync),
         .freq_i  (tone_freq[t]),
         .phase_i (tone_phase[t]),
         .scale_i (tone_scale[t]),
         .tone_q  (tone_val[t])
      );
   end

   always_comb begin
      tone_sum = '0;
      for (int i = 0; i < NUM_TONES; i++) begin
         tone_sum = tone_sum + SUMW'(tone_val[i]);
      end
      if (tone_sum > SAT_HI) begin
         sat_val = DW'(SAT_HI);
      end else if (tone_sum < SAT_LO) begin
         sat_val = DW'(SAT_LO);
      end else begin
         sat_val = DW'(tone_sum);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sample_out <= '0;
      end else if (!enable) begin
         sample_out <= '0;
      end else if (data_sel == SEL_TONE) begin
         sample_out <= sat_val;
      end else if (data_sel == SEL_EXT) begin
         sample_out <= ext_sample;
      end else begin
         sample_out <= '0;
      end
   end

   // R8
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (sample_out == '0));

   // R9
   ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && data_sel == SEL_EXT) |=> (sample_out == $past(ext_sample)));

   // R10
   mute_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_sel != SEL_EXT && data_sel != SEL_TONE) |=> (sample_out == '0));

endmodule

// File: tb/dds_dual_tone_chan_test.sv
module dds_dual_tone_chan_test;

   localparam int  CLK_PERIOD = 10;
   localparam real PI_R       = 3.14159265358979;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    enable = 1'b0;
   logic                    sync = 1'b0;
   logic [1:0][15:0]        tf = '0;
   logic [1:0][15:0]        tp = '0;
   logic [1:0][15:0]        ts = '0;
   logic [3:0]              sel = 4'd0;
   logic signed [15:0]      ext = '0;
   logic signed [15:0]      out_s;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dds_dual_tone_chan uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .sync       (sync),
      .tone_freq  (tf),
      .tone_phase (tp),
      .tone_scale (ts),
      .data_sel   (sel),
      .ext_sample (ext),
      .sample_out (out_s)
   );

   function automatic real tone_real(int ph, int sc);
      int  k;
      int  sv;
      real ang;
      real v;
      k   = (ph & 32'hFFFF) >> 4;
      ang = (real'(k) + 0.5) * 2.0 * PI_R / 4096.0;
      sv  = $rtoi($floor(32767.0 * $sin(ang) + 0.5));
      v   = real'(sv) * real'(sc & 32'h7FFF) / 16384.0;
      return ((sc & 32'h8000) != 0) ? -v : v;
   endfunction

   function automatic int expect_at(int n);
      real s;
      int  r;
      s = 0.0;
      for (int i = 0; i < 2; i++) begin
         s = s + tone_real(n * int'(tf[i]) + int'(tp[i]), int'(ts[i]));
      end
      r = $rtoi($floor(s + 0.5));
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   task automatic check(string tag, int act, int exp, int tol);
      int d;
      checks++;
      d = act - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic sync_pulse();
      @(negedge clk) sync = 1'b1;
      @(negedge clk) sync = 1'b0;
   endtask

   // After the sync edge, sample n is due after edge n+3
   task automatic run_tone(string tag, int nsamp, int tol);
      sync_pulse();
      repeat (3) @(negedge clk);
      for (int n = 0; n < nsamp; n++) begin
         check(tag, int'(out_s), expect_at(n), tol);
         @(negedge clk);
      end
   endtask

   task automatic set_tone(int i, int f, int p, int s);
      tf[i] = 16'(f);
      tp[i] = 16'(p);
      ts[i] = 16'(s);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 in reset", int'(out_s), 0, 0);
      rst_n  = 1'b1;
      enable = 1'b1;
      set_tone(0, 16'h0100, 0, 16'h4000);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R1 no tone before sync", int'(out_s), 0, 0);
      end

      // R2: full table sweep, one index per sample
      set_tone(0, 16'h0010, 0, 16'h4000);
      set_tone(1, 0, 0, 0);
      run_tone("R2 table sweep", 4096, 2);

      // R2/R3: varied words, offsets, gains
      set_tone(0, 16'h0ABC, 16'h1234, 16'h2000);
      run_tone("R2 word 0x0ABC", 64, 3);
      set_tone(0, 16'h0001, 16'h8000, 16'h4000);
      run_tone("R2 slow word", 32, 2);
      set_tone(0, 16'h0300, 0, 16'h8000 | 16'h4000);
      run_tone("R3 negative gain", 48, 3);
      set_tone(0, 16'h0450, 16'h0777, 16'h7FFF);
      run_tone("R3 near-2 gain", 48, 4);

      // R4: summed tones
      set_tone(0, 16'h1357, 16'h0100, 16'h3000);
      set_tone(1, 16'h2468, 16'hA000, 16'h8000 | 16'h2000);
      run_tone("R4 two-tone sum", 64, 4);
      set_tone(0, 0, 16'h4000, 16'h7FFF);
      set_tone(1, 0, 16'h4000, 16'h7FFF);
      run_tone("R4 clamp high", 4, 0);
      set_tone(0, 0, 16'hC000, 16'h7FFF);
      set_tone(1, 0, 16'hC000, 16'h7FFF);
      run_tone("R4 clamp low", 4, 0);
      set_tone(0, 0, 16'h4000, 16'hFFFF);
      set_tone(1, 0, 16'h4000, 16'hFFFF);
      run_tone("R4 clamp via sign", 4, 0);

      // R11: half-rate word
      set_tone(0, 16'h8000, 16'h1000, 16'h4000);
      set_tone(1, 0, 0, 0);
      run_tone("R11 half rate", 16, 2);

      // R6 then R5: hold a constant level, change inputs without sync
      set_tone(0, 0, 16'h4000, 16'h4000);
      run_tone("R6 setup", 2, 2);
      tp[0] = 16'hC000;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check("R6 no effect before sync", int'(out_s), 32767, 2);
      end
      sync_pulse();
      repeat (2) @(negedge clk);
      check("R5 old value at edge 2", int'(out_s), 32767, 2);
      @(negedge clk);
      check("R5 new value at edge 3", int'(out_s), -32767, 2);

      // R9: external pass-through
      sel = 4'd2;
      for (int i = 0; i < 20; i++) begin
         ext = 16'((i * 4567) - 30000);
         @(negedge clk);
         check("R9 ext sample", int'(out_s), int'(ext), 0);
      end
      ext = 16'h8000;
      @(negedge clk);
      check("R9 ext minimum", int'(out_s), -32768, 0);

      // R10: other codes mute, code 0 restores the tone
      for (int c = 0; c < 16; c++) begin
         if (c != 0 && c != 2) begin
            sel = 4'(c);
            repeat (2) @(negedge clk);
            check("R10 muted code", int'(out_s), 0, 0);
         end
      end
      sel = 4'd0;
      repeat (2) @(negedge clk);
      check("R10 tone code", int'(out_s), -32767, 2);

      // R8: disable, realign while idle, then resume from held phase
      enable = 1'b0;
      @(negedge clk);
      check("R8 zero when disabled", int'(out_s), 0, 0);
      set_tone(0, 16'h0040, 0, 16'h4000);
      sync_pulse();
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check("R8 idle output", int'(out_s), 0, 0);
      end
      enable = 1'b1;
      for (int m = 0; m < 12; m++) begin
         @(negedge clk);
         check("R8 resume from held phase", int'(out_s),
               expect_at((m < 3) ? 0 : m - 2), 2);
      end

      // R7: sync restarts the phase mid-run
      run_tone("R7 restart", 8, 2);

      // R1: reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run", int'(out_s), 0, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule